// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a down-counting interval timer that sits on a simple synchronous register bus. Software programs a modulus and a control word. The counter then steps down once per prescaled tick. A tick comes every `2 * 2^pre` clock cycles, where `pre` is a four-bit field in the control word, so the division runs from 2 to 65536 cycles. When the count reaches zero the next tick raises an interrupt flag, and the counter reloads. It reloads either from the modulus (reload mode) or from the full all-ones value (free-running mode).

The interrupt output is a level. It stays high while the flag and its enable bit are both set, and software clears it by writing a one to the flag bit. Two other actions also affect the counter and the flag. A write to the modulus always drops a pending flag. If the overwrite option is set, a modulus write also forces the new value into the running counter at once. A control write that only touches the interrupt enable bit, or only clears the flag, leaves the count and the prescaler phase alone. Any other control write restarts the prescaler phase.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control word, the modulus and the count all read 0x0000, and `irq` is low.
- R2: Control word layout: bit 0 run, bit 1 reload mode, bit 2 interrupt flag, bit 3 interrupt enable, bit 4 overwrite, bit 5 and bit 6 stored spare mode bits, bits 11:8 prescale. Bit 7 and bits 15:12 read as zero. The modulus is read/write. Byte offsets are 0 for control, 2 for modulus and 4 for count. Reads return data on the cycle after the request, and any other offset reads 0x0000.
- R3: The count at offset 4 is read-only. A write there changes neither the count nor any other register.
- R4: When the run bit goes from 0 to 1, the counter loads its limit: the modulus if the reload bit is 1, and 0xFFFF otherwise. While the run bit is 0 the count holds.
- R5: While running, the count decrements by one every `2 * 2^pre` clock cycles.
- R6: The tick that finds the count at zero sets the flag and reloads the limit. With the counter started from the limit, the first expiry therefore comes `(limit+1) * 2 * 2^pre` cycles after the enabling write.
- R7: Writing 1 to control bit 2 clears the flag. Writing 0 there leaves it unchanged.
- R8: `irq` is high exactly when the flag and the interrupt enable bit are both 1.
- R9: Any write to the modulus clears the flag.
- R10: With overwrite set, the count equals the written modulus on the cycle after the write. With overwrite clear, the count is not touched by the write.
- R11: A control write that differs from the stored word only in bit 3 and/or bit 2 keeps both the count and the prescaler phase.
- R12: Any other control write restarts the prescaler phase. If the run bit stays 1, the current count is kept and not reloaded.
- R13: If a flag-clearing control write lands on the same cycle as an expiry, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the exact cycle of the first expiry. A counter that is off by one in its reload or in its prescale mask would raise `irq` one tick early or late. The bench also forces a phase-known restart and then compares a harmless enable-only write against a spare-bit write over a 16-cycle window. A design that treats every control write as a restart, or none, would show the wrong count difference. The remaining attacks cover three cases. One is a flag clear that collides with an expiry, which an inverted priority would lose. Another is a modulus write with and without overwrite, where a wrong design would jump the count or leave it. The last is a write to the read-only count, which a leaky decode would take.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   // control word bit positions (software decodes these)
   localparam int BIT_RUN   = 0;
   localparam int BIT_RLD   = 1;
   localparam int BIT_FLAG  = 2;
   localparam int BIT_IEN   = 3;
   localparam int BIT_OVW   = 4;
   localparam int BIT_SPA   = 5;
   localparam int BIT_SPB   = 6;
   localparam int PRE_LSB   = 8;

   // byte offsets of the register window
   localparam logic [2:0] OFS_CTL = 3'd0;
   localparam logic [2:0] OFS_MOD = 3'd2;
   localparam logic [2:0] OFS_CNT = 3'd4;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTL  = 2'd1,
      SEL_MOD  = 2'd2,
      SEL_CNT  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
   parameter int PRE_W      = 4,
   parameter int HALF_STAGE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);
   // phase counter wide enough for the largest division
   localparam int PH_W = (1 << PRE_W) - 1 + HALF_STAGE;

   if (PRE_W < 1) begin : g_bad_pre
      $error("ptmr_prescale: PRE_W must be at least 1");
   end
   if (HALF_STAGE != 0 && HALF_STAGE != 1) begin : g_bad_half
      $error("ptmr_prescale: HALF_STAGE must be 0 or 1");
   end

   logic [PH_W-1:0]  phase;
   logic [PH_W-1:0]  mask;
   logic [PRE_W:0]   sel;

   // number of low phase bits that must all be ones for a tick
   if (HALF_STAGE == 1) begin : g_half
      assign sel = {1'b0, pre} + (PRE_W+1)'(1);
   end else begin : g_full
      assign sel = {1'b0, pre};
   end

   always_comb begin
      mask = (PH_W'(1) << sel) - PH_W'(1);
   end

   assign tick = run && ((phase & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (restart || !run) begin
         phase <= '0;
      end else begin
         phase <= phase + PH_W'(1);
      end
   end

   // R5: with the fixed half stage a tick is never followed by another
   if (HALF_STAGE == 1) begin : g_chk
      p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !restart) |=> !tick)
         else $error("tick repeated on consecutive cycles");
   end

   // R12: a restart puts the phase back to its start
   p_restart_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0))
      else $error("phase not restarted");
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   if (CNT_W < 2) begin : g_bad_w
      $error("ptmr_counter: CNT_W must be at least 2");
   end

   logic at_zero;
   assign at_zero = (cnt == '0);
   assign expire  = run && tick && at_zero && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (run && tick) begin
         cnt <= at_zero ? limit : (cnt - CNT_W'(1));
      end
   end

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && (cnt == '0) && !load) |=> (cnt == $past(limit)))
      else $error("expiry did not reload the limit");

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && (cnt != '0) && !load) |=> (cnt == $past(cnt) - CNT_W'(1)))
      else $error("count did not step down by one");

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt))
      else $error("stopped count moved");
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic              wr_mod,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic              run,
   output logic              rld,
   output logic              ien,
   output logic              ovw,
   output logic              flag,
   output logic [PRE_W-1:0]  pre,
   output logic [CNT_W-1:0]  mod_q,
   output logic [DATA_W-1:0] ctl_view,
   output logic              restart,
   output logic              run_rise
);
   localparam int TOP_BIT = PRE_LSB + PRE_W;

   if (DATA_W < TOP_BIT) begin : g_bad_data
      $error("ptmr_regs: DATA_W too small for the prescale field");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("ptmr_regs: CNT_W must not exceed DATA_W");
   end

   logic spa, spb;
   logic cfg_same;

   // only bits 3 and 2 may differ for a write to count as harmless
   assign cfg_same = (wdata[BIT_RUN] == run) &&
                     (wdata[BIT_RLD] == rld) &&
                     (wdata[BIT_OVW] == ovw) &&
                     (wdata[BIT_SPA] == spa) &&
                     (wdata[BIT_SPB] == spb) &&
                     (wdata[PRE_LSB +: PRE_W] == pre);

   assign restart  = wr_ctl && !cfg_same;
   assign run_rise = wr_ctl && wdata[BIT_RUN] && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         rld <= 1'b0;
         ien <= 1'b0;
         ovw <= 1'b0;
         spa <= 1'b0;
         spb <= 1'b0;
         pre <= '0;
      end else if (wr_ctl) begin
         run <= wdata[BIT_RUN];
         rld <= wdata[BIT_RLD];
         ien <= wdata[BIT_IEN];
         ovw <= wdata[BIT_OVW];
         spa <= wdata[BIT_SPA];
         spb <= wdata[BIT_SPB];
         pre <= wdata[PRE_LSB +: PRE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q <= '0;
      end else if (wr_mod) begin
         mod_q <= wdata[CNT_W-1:0];
      end
   end

   // hardware set wins over any same-cycle software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (expire) begin
         flag <= 1'b1;
      end else if ((wr_ctl && wdata[BIT_FLAG]) || wr_mod) begin
         flag <= 1'b0;
      end
   end

   always_comb begin
      ctl_view                    = '0;
      ctl_view[BIT_RUN]           = run;
      ctl_view[BIT_RLD]           = rld;
      ctl_view[BIT_FLAG]          = flag;
      ctl_view[BIT_IEN]           = ien;
      ctl_view[BIT_OVW]           = ovw;
      ctl_view[BIT_SPA]           = spa;
      ctl_view[BIT_SPB]           = spb;
      ctl_view[PRE_LSB +: PRE_W]  = pre;
   end

   logic unused_gap;
   assign unused_gap = wdata[7];
   if (DATA_W > TOP_BIT) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:TOP_BIT];
   end

   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag)
      else $error("expiry did not set the flag");

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && wdata[BIT_FLAG] && !expire) |=> !flag)
      else $error("write-one did not clear the flag");

   p_w0_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !wdata[BIT_FLAG] && flag) |=> flag)
      else $error("write-zero disturbed the flag");

   p_mod_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mod && !expire) |=> !flag)
      else $error("modulus write left the flag set");

   p_race_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && wr_ctl) |=> flag)
      else $error("clear beat a same-cycle expiry");
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 16,
   parameter int PRE_W      = 4,
   parameter int HALF_STAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(OFS_MOD);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
   localparam logic [CNT_W-1:0]  FULL  = '1;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ptmr_top: ADDR_W must be at least 3");
   end

   reg_sel_e          sel;
   logic              wr_ctl, wr_mod, rd_req;
   logic              run, rld, ien, ovw, flag;
   logic [PRE_W-1:0]  pre;
   logic [CNT_W-1:0]  mod_q, cnt, limit, load_val, start_limit;
   logic [DATA_W-1:0] ctl_view, rd_mux;
   logic              restart, run_rise, tick, expire, load;

   always_comb begin
      if      (bus_addr == A_CTL) sel = SEL_CTL;
      else if (bus_addr == A_MOD) sel = SEL_MOD;
      else if (bus_addr == A_CNT) sel = SEL_CNT;
      else                        sel = SEL_NONE;
   end

   assign wr_ctl = bus_valid && bus_write && (sel == SEL_CTL);
   assign wr_mod = bus_valid && bus_write && (sel == SEL_MOD);
   assign rd_req = bus_valid && !bus_write;

   ptmr_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PRE_W  (PRE_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (wr_ctl),
      .wr_mod   (wr_mod),
      .wdata    (bus_wdata),
      .expire   (expire),
      .run      (run),
      .rld      (rld),
      .ien      (ien),
      .ovw      (ovw),
      .flag     (flag),
      .pre      (pre),
      .mod_q    (mod_q),
      .ctl_view (ctl_view),
      .restart  (restart),
      .run_rise (run_rise)
   );

   // live limit for reloads; start limit uses the reload bit being written
   assign limit       = rld ? mod_q : FULL;
   assign start_limit = bus_wdata[BIT_RLD] ? mod_q : FULL;
   assign load        = run_rise || (wr_mod && ovw);
   assign load_val    = run_rise ? start_limit : bus_wdata[CNT_W-1:0];

   ptmr_prescale #(
      .PRE_W      (PRE_W),
      .HALF_STAGE (HALF_STAGE)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .pre     (pre),
      .tick    (tick)
   );

   ptmr_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .load     (load),
      .load_val (load_val),
      .limit    (limit),
      .cnt      (cnt),
      .expire   (expire)
   );

   always_comb begin
      unique case (sel)
         SEL_CTL: rd_mux = ctl_view;
         SEL_MOD: rd_mux = DATA_W'(mod_q);
         SEL_CNT: rd_mux = DATA_W'(cnt);
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_req) begin
         bus_rdata <= rd_mux;
      end else begin
         bus_rdata <= '0;
      end
   end

   assign irq = flag && ien;

   p_ro_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && (sel == SEL_CNT) && !run) |=> $stable(cnt))
      else $error("write to count offset changed the count");

   p_ovw_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mod && ovw) |=> (cnt == $past(bus_wdata[CNT_W-1:0])))
      else $error("overwrite did not load the counter");

   p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_rise |=> (cnt == $past(start_limit)))
      else $error("start did not load the limit");
endmodule

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
   localparam logic [2:0] A_CTL = 3'd0;
   localparam logic [2:0] A_MOD = 3'd2;
   localparam logic [2:0] A_CNT = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   ptmr_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input logic [15:0] act,
                            input logic [15:0] lo, input logic [15:0] hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h..0x%04h", req, act, lo, hi);
      end
   endtask

   // every bus task starts and ends at a falling edge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(A_CTL, v); check("R1 ctl", v, 16'h0000);
      rd(A_MOD, v); check("R1 mod", v, 16'h0000);
      rd(A_CNT, v); check("R1 cnt", v, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'h0000);
   endtask

   task automatic t_map();
      logic [15:0] v;
      wr(A_MOD, 16'hBEEF); rd(A_MOD, v); check("R2 mod rw", v, 16'hBEEF);
      wr(A_CTL, 16'h0F60); rd(A_CTL, v); check("R2 ctl fields", v, 16'h0F60);
      wr(A_CTL, 16'hF080); rd(A_CTL, v); check("R2 reserved zero", v, 16'h0000);
      rd(3'd6, v); check("R2 unmapped 6", v, 16'h0000);
      rd(3'd1, v); check("R2 unmapped 1", v, 16'h0000);
   endtask

   task automatic t_start();
      logic [15:0] v, w;
      wr(A_MOD, 16'd5);
      wr(A_CTL, 16'h0003);
      rd(A_CNT, v); check("R4 reload start", v, 16'd5);
      wr(A_CTL, 16'h0000);
      rd(A_CNT, v); idle(20); rd(A_CNT, w); check("R4 hold", w, v);
      wr(A_CTL, 16'h0001);
      rd(A_CNT, v); check("R4 free start", v, 16'hFFFF);
      wr(A_CTL, 16'h0000);
   endtask

   task automatic t_rate();
      logic [15:0] a, b;
      wr(A_CTL, 16'h0001);
      rd(A_CNT, a); idle(63); rd(A_CNT, b);
      check("R5 div2 steps", a - b, 16'd32);
      wr(A_CTL, 16'h0000);
      wr(A_CTL, 16'h0201);
      rd(A_CNT, a); idle(63); rd(A_CNT, b);
      check("R5 div8 steps", a - b, 16'd8);
      wr(A_CTL, 16'h0000);
   endtask

   task automatic t_period();
      logic [15:0] v;
      wr(A_MOD, 16'd3);
      wr(A_CTL, 16'h000B);
      idle(7); check("R6 no early irq", {15'd0, irq}, 16'h0000);
      idle(1); check("R6 irq at expiry", {15'd0, irq}, 16'h0001);
      rd(A_CNT, v); check("R6 reload value", v, 16'd3);
      wr(A_CTL, 16'h0000);
      check("R8 flag without enable", {15'd0, irq}, 16'h0000);
      rd(A_CTL, v); check("R8 flag held", v, 16'h0004);
      wr(A_CTL, 16'h0008);
      check("R8 enable raises irq", {15'd0, irq}, 16'h0001);
      wr(A_CTL, 16'h0008);
      check("R7 write0 keeps", {15'd0, irq}, 16'h0001);
      wr(A_CTL, 16'h000C);
      check("R7 write1 clears irq", {15'd0, irq}, 16'h0000);
      rd(A_CTL, v); check("R7 flag cleared", v, 16'h0008);
   endtask

   task automatic t_mod_clear();
      logic [15:0] v;
      wr(A_CTL, 16'h0000);
      wr(A_CTL, 16'h000B);
      idle(8);
      wr(A_CTL, 16'h0008);
      check("R9 flag pending", {15'd0, irq}, 16'h0001);
      wr(A_MOD, 16'd7);
      check("R9 irq dropped", {15'd0, irq}, 16'h0000);
      rd(A_CTL, v); check("R9 flag cleared", v, 16'h0008);
      wr(A_CTL, 16'h0000);
   endtask

   task automatic t_ovw();
      logic [15:0] v;
      wr(A_CTL, 16'h0011);
      wr(A_MOD, 16'h1234);
      rd(A_CNT, v); check("R10 overwrite load", v, 16'h1234);
      wr(A_CTL, 16'h0001);
      wr(A_MOD, 16'h0100);
      rd(A_CNT, v); check_rng("R10 no overwrite / R12 keep count", v, 16'h1232, 16'h1234);
      wr(A_CTL, 16'h0000);
   endtask

   task automatic t_phase();
      logic [15:0] a, b;
      wr(A_MOD, 16'd1000);
      wr(A_CTL, 16'h0303);
      rd(A_CNT, a); check("R4 start 1000", a, 16'd1000);
      idle(6); wr(A_CTL, 16'h030B);
      idle(8); rd(A_CNT, b);
      check("R11 light write keeps phase", b, 16'd999);
      wr(A_CTL, 16'h0000);
      wr(A_CTL, 16'h0303);
      rd(A_CNT, a);
      idle(6); wr(A_CTL, 16'h0343);
      idle(8); rd(A_CNT, b);
      check("R12 heavy write restarts phase", b, 16'd1000);
      wr(A_CTL, 16'h0000);
   endtask

   task automatic t_readonly();
      logic [15:0] a, b;
      rd(A_CNT, a);
      wr(A_CNT, 16'h0000);
      rd(A_CNT, b); check("R3 count unchanged", b, a);
      rd(A_MOD, b); check("R3 modulus unchanged", b, 16'd1000);
      rd(A_CTL, b); check("R3 control unchanged", b, 16'h0000);
   endtask

   task automatic t_race();
      logic [15:0] v;
      wr(A_CTL, 16'h0004);
      wr(A_MOD, 16'd3);
      wr(A_CTL, 16'h0003);
      idle(7);
      wr(A_CTL, 16'h0007);
      rd(A_CTL, v); check("R13 set wins over clear", v, 16'h0007);
      wr(A_CTL, 16'h0004);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_map();
      wr(A_CTL, 16'h0000);
      t_start();
      t_rate();
      t_period();
      t_mod_clear();
      t_ovw();
      t_phase();
      t_readonly();
      t_race();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule